// File: doc/BRIEF.md
# Multicycle Load-Store Integer Core

This block is a small 32-bit integer processor that runs one instruction at a time. Each instruction passes through a fixed series of steps, one clock cycle per step: fetch, decode and operand read, execute or address calculation, memory access or branch resolution, and write-back. A finite state machine drives the step sequence. It issues the enables for the internal holding registers (instruction, next-PC, two operands, immediate, ALU result, branch condition and load data), the operand multiplexer selects, and the memory write strobe.

The core uses one memory port for both instructions and data. The memory returns read data combinationally from the address, and it commits a write on the rising clock edge when the write strobe is high. Stores and branches finish after the memory step and skip write-back. Instructions that produce a register result take one more cycle.

Top module: `mc_core`

## Requirements
- R1: While `rst_n` is low, `mem_we` is 0 and `mem_addr` equals `RESET_PC` (default 0). The first cycle after release is the fetch of the word at `RESET_PC`.
- R2: In the fetch cycle the core reads the word at `mem_addr` = PC. The sequential successor is PC+4. In every cycle outside the memory step of a load or store, `mem_addr` shows the PC register, which is updated at the end of the memory step.
- R3: Steps always run fetch, decode, execute, memory. Register-register, register-immediate and load instructions then take a write-back cycle (5 cycles in total). Stores, branches and unknown opcodes return to fetch after the memory step (4 cycles).
- R4: The instruction fields are opcode [31:26], first source [25:21], second field [20:16], register-register destination [15:11], function [10:0] and immediate [15:0]. The immediate is sign-extended. Opcodes: 0x00 register-register, 0x08 add-imm, 0x0A set-less-imm, 0x0C and-imm, 0x0D or-imm, 0x0E xor-imm, 0x23 load word, 0x2B store word, 0x04 branch-if-zero, 0x05 branch-if-nonzero.
- R5: Register-register operations write `rs op rt` to the register in [15:11]. Function values: 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x26 xor, 0x2A signed set-less-than. Any other function value writes 0.
- R6: Register-immediate operations write `rs op sext(imm)` to the register in [20:16]. Set-less-than is signed.
- R7: A load drives `mem_addr` = rs + sext(imm) in its memory step and writes the returned word to the register in [20:16].
- R8: A store drives `mem_addr` = rs + sext(imm), `mem_we` = 1 and `mem_wdata` = the value of the register in [20:16] in its memory step. In all other cycles `mem_we` and `mem_wdata` are 0.
- R9: Branch-if-zero is taken when rs equals 0. Branch-if-nonzero is taken when rs differs from 0. A taken branch continues at PC+4+sext(imm), a byte offset. A branch that is not taken continues at PC+4.
- R10: Register 0 reads as 0. Writes to it are discarded.
- R11: An unknown opcode changes no register and no memory word, and the next fetch is at PC+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 32 | Byte address for the memory port |
| mem_wdata | output | 32 | Store data, 0 when not writing |
| mem_we | output | 1 | Write strobe for the memory port |
| mem_rdata | input | 32 | Word read at `mem_addr`, combinational |

## Verification
Every cycle drives `mem_addr`, so a wrong step, PC or effective address shows up on the port in the cycle it happens. A corrupted register value only appears later, when a store or a branch uses that register. The bench therefore compares the whole port trace cycle by cycle against a behavioural instruction model, and it chains register results into stores and loop-controlling branches. A late or missing write-back cycle shifts every following fetch address by one cycle and is caught at once. An effect that must be ignored, such as a write to register 0 or an unknown opcode, is brought out by storing the affected register afterwards.

// File: rtl/mc_pkg.sv
package mc_pkg;

    localparam logic [5:0] OP_REG  = 6'h00;
    localparam logic [5:0] OP_ADDI = 6'h08;
    localparam logic [5:0] OP_SLTI = 6'h0A;
    localparam logic [5:0] OP_ANDI = 6'h0C;
    localparam logic [5:0] OP_ORI  = 6'h0D;
    localparam logic [5:0] OP_XORI = 6'h0E;
    localparam logic [5:0] OP_LW   = 6'h23;
    localparam logic [5:0] OP_SW   = 6'h2B;
    localparam logic [5:0] OP_BEQZ = 6'h04;
    localparam logic [5:0] OP_BNEZ = 6'h05;

    localparam logic [10:0] FN_ADD = 11'h020;
    localparam logic [10:0] FN_SUB = 11'h022;
    localparam logic [10:0] FN_AND = 11'h024;
    localparam logic [10:0] FN_OR  = 11'h025;
    localparam logic [10:0] FN_XOR = 11'h026;
    localparam logic [10:0] FN_SLT = 11'h02A;

    typedef enum logic [2:0] {
        ST_IF, ST_ID, ST_EX, ST_MEM, ST_WB
    } step_e;

    typedef enum logic [2:0] {
        K_REG, K_IMM, K_LOAD, K_STORE, K_BEQZ, K_BNEZ, K_NOP
    } kind_e;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_SLT, ALU_ZERO
    } alu_op_e;

    typedef struct packed {
        logic    opr_en;     // capture operands and immediate
        logic    alu_en;     // capture ALU result
        logic    cond_en;    // capture branch condition
        logic    cond_ne;    // condition is "not zero"
        logic    lmd_en;     // capture load data
        logic    pc_en;      // update PC
        logic    pc_take;    // PC takes the ALU result
        logic    ea_sel;     // memory port shows effective address
        logic    mem_we;     // store strobe
        logic    rf_we;      // register write-back
        logic    wb_lmd;     // write-back source is load data
        logic    dst_rtype;  // destination from bits 15..11
        logic    a_npc;      // ALU first input is NPC
        logic    b_imm;      // ALU second input is immediate
        alu_op_e alu_op;
    } ctrl_t;

    function automatic kind_e decode_kind(logic [5:0] op);
        case (op)
            OP_REG:                                  return K_REG;
            OP_ADDI, OP_SLTI, OP_ANDI, OP_ORI, OP_XORI: return K_IMM;
            OP_LW:                                   return K_LOAD;
            OP_SW:                                   return K_STORE;
            OP_BEQZ:                                 return K_BEQZ;
            OP_BNEZ:                                 return K_BNEZ;
            default:                                 return K_NOP;
        endcase
    endfunction

    function automatic alu_op_e fn_to_alu(logic [10:0] fn);
        case (fn)
            FN_ADD:  return ALU_ADD;
            FN_SUB:  return ALU_SUB;
            FN_AND:  return ALU_AND;
            FN_OR:   return ALU_OR;
            FN_XOR:  return ALU_XOR;
            FN_SLT:  return ALU_SLT;
            default: return ALU_ZERO;
        endcase
    endfunction

    function automatic alu_op_e op_to_alu(logic [5:0] op);
        case (op)
            OP_ADDI: return ALU_ADD;
            OP_SLTI: return ALU_SLT;
            OP_ANDI: return ALU_AND;
            OP_ORI:  return ALU_OR;
            OP_XORI: return ALU_XOR;
            default: return ALU_ZERO;
        endcase
    endfunction

endpackage

// File: rtl/mc_alu.sv
module mc_alu
    import mc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  alu_op_e          op_i,
    input  logic [XLEN-1:0]  a_i,
    input  logic [XLEN-1:0]  b_i,
    output logic [XLEN-1:0]  y_o
);

    always_comb begin
        unique case (op_i)
            ALU_ADD:  y_o = a_i + b_i;
            ALU_SUB:  y_o = a_i - b_i;
            ALU_AND:  y_o = a_i & b_i;
            ALU_OR:   y_o = a_i | b_i;
            ALU_XOR:  y_o = a_i ^ b_i;
            ALU_SLT:  y_o = XLEN'($signed(a_i) < $signed(b_i));
            default:  y_o = '0;
        endcase
    end

endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
    parameter int XLEN = 32,
    parameter int NREG = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   ra1_i,
    input  logic [AW-1:0]   ra2_i,
    output logic [XLEN-1:0] rd1_o,
    output logic [XLEN-1:0] rd2_o,
    input  logic            we_i,
    input  logic [AW-1:0]   wa_i,
    input  logic [XLEN-1:0] wd_i
);

    logic [XLEN-1:0] regs_q [NREG];
    logic [XLEN-1:0] regs_d [NREG];

    always_comb begin
        regs_d = regs_q;
        if (we_i && (wa_i != '0)) begin
            regs_d[wa_i] = wd_i;
        end
        regs_d[0] = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                regs_q[i] <= '0;
            end
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rd1_o = regs_q[ra1_i];
    assign rd2_o = regs_q[ra2_i];

endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
    import mc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [5:0]  opcode_i,
    input  logic [10:0] funct_i,
    input  logic        cond_i,
    output step_e       step_o,
    output ctrl_t       ctrl_o
);

    step_e step_d, step_q;
    kind_e kind;
    ctrl_t c;

    always_comb begin
        kind   = decode_kind(opcode_i);
        c      = '0;
        step_d = step_q;
        unique case (step_q)
            ST_IF: begin
                step_d = ST_ID;
            end
            ST_ID: begin
                c.opr_en = 1'b1;
                step_d   = ST_EX;
            end
            ST_EX: begin
                c.alu_en = 1'b1;
                step_d   = ST_MEM;
                case (kind)
                    K_REG: c.alu_op = fn_to_alu(funct_i);
                    K_IMM: begin
                        c.b_imm  = 1'b1;
                        c.alu_op = op_to_alu(opcode_i);
                    end
                    K_LOAD, K_STORE: begin
                        c.b_imm  = 1'b1;
                        c.alu_op = ALU_ADD;
                    end
                    K_BEQZ, K_BNEZ: begin
                        c.a_npc   = 1'b1;
                        c.b_imm   = 1'b1;
                        c.alu_op  = ALU_ADD;
                        c.cond_en = 1'b1;
                        c.cond_ne = (kind == K_BNEZ);
                    end
                    default: c.alu_en = 1'b0;
                endcase
            end
            ST_MEM: begin
                c.pc_en   = 1'b1;
                c.pc_take = ((kind == K_BEQZ) || (kind == K_BNEZ)) && cond_i;
                if (kind == K_LOAD) begin
                    c.ea_sel = 1'b1;
                    c.lmd_en = 1'b1;
                end
                if (kind == K_STORE) begin
                    c.ea_sel = 1'b1;
                    c.mem_we = 1'b1;
                end
                if ((kind == K_REG) || (kind == K_IMM) || (kind == K_LOAD)) begin
                    step_d = ST_WB;
                end else begin
                    step_d = ST_IF;
                end
            end
            ST_WB: begin
                c.rf_we     = 1'b1;
                c.wb_lmd    = (kind == K_LOAD);
                c.dst_rtype = (kind == K_REG);
                step_d      = ST_IF;
            end
            default: step_d = ST_IF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= ST_IF;
        end else begin
            step_q <= step_d;
        end
    end

    assign step_o = step_q;
    assign ctrl_o = c;

endmodule

// File: rtl/mc_core.sv
module mc_core
    import mc_pkg::*;
#(
    parameter int          XLEN     = 32,
    parameter int          NREG     = 32,
    parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [XLEN-1:0] mem_addr,
    output logic [XLEN-1:0] mem_wdata,
    output logic            mem_we,
    input  logic [XLEN-1:0] mem_rdata
);

    localparam int AW     = $clog2(NREG);
    localparam int IMM_W  = 16;
    localparam int EXT_W  = XLEN - IMM_W;

    typedef struct packed {
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] npc;
        logic [XLEN-1:0] ir;
        logic [XLEN-1:0] a;
        logic [XLEN-1:0] b;
        logic [XLEN-1:0] imm;
        logic [XLEN-1:0] alu;
        logic            cond;
        logic [XLEN-1:0] lmd;
    } dp_t;

    dp_t             dp_d, dp_q;
    step_e           step;
    ctrl_t           ctl;
    logic [XLEN-1:0] rd1, rd2;
    logic [XLEN-1:0] alu_a, alu_b, alu_y;
    logic [AW-1:0]   wa;
    logic [XLEN-1:0] wd;

    mc_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .opcode_i (dp_q.ir[31:26]),
        .funct_i  (dp_q.ir[10:0]),
        .cond_i   (dp_q.cond),
        .step_o   (step),
        .ctrl_o   (ctl)
    );

    assign wa = ctl.dst_rtype ? dp_q.ir[15:11] : dp_q.ir[20:16];
    assign wd = ctl.wb_lmd ? dp_q.lmd : dp_q.alu;

    mc_regfile #(
        .XLEN (XLEN),
        .NREG (NREG)
    ) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .ra1_i (dp_q.ir[25:21]),
        .ra2_i (dp_q.ir[20:16]),
        .rd1_o (rd1),
        .rd2_o (rd2),
        .we_i  (ctl.rf_we),
        .wa_i  (wa),
        .wd_i  (wd)
    );

    assign alu_a = ctl.a_npc ? dp_q.npc : dp_q.a;
    assign alu_b = ctl.b_imm ? dp_q.imm : dp_q.b;

    mc_alu #(
        .XLEN (XLEN)
    ) u_alu (
        .op_i (ctl.alu_op),
        .a_i  (alu_a),
        .b_i  (alu_b),
        .y_o  (alu_y)
    );

    always_comb begin
        dp_d = dp_q;
        if (step == ST_IF) begin
            dp_d.ir  = mem_rdata;
            dp_d.npc = dp_q.pc + XLEN'(4);
        end
        if (ctl.opr_en) begin
            dp_d.a   = rd1;
            dp_d.b   = rd2;
            dp_d.imm = {{EXT_W{dp_q.ir[IMM_W-1]}}, dp_q.ir[IMM_W-1:0]};
        end
        if (ctl.alu_en) begin
            dp_d.alu = alu_y;
        end
        if (ctl.cond_en) begin
            dp_d.cond = ctl.cond_ne ? (dp_q.a != '0) : (dp_q.a == '0);
        end
        if (ctl.lmd_en) begin
            dp_d.lmd = mem_rdata;
        end
        if (ctl.pc_en) begin
            dp_d.pc = ctl.pc_take ? dp_q.alu : dp_q.npc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dp_q    <= '0;
            dp_q.pc <= RESET_PC;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign mem_addr  = ctl.ea_sel ? dp_q.alu : dp_q.pc;
    assign mem_we    = ctl.mem_we;
    assign mem_wdata = ctl.mem_we ? dp_q.b : '0;

endmodule

// File: rtl/mc_core_chk.sv
module mc_core_chk
    import mc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input step_e           step_i,
    input logic [XLEN-1:0] pc_i,
    input logic [XLEN-1:0] npc_i,
    input logic [XLEN-1:0] a_i,
    input logic [XLEN-1:0] ir_i,
    input logic            mem_we_i
);

    // R3
    if_then_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i == ST_IF) |=> (step_i == ST_ID));

    // R3
    id_then_ex_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i == ST_ID) |=> (step_i == ST_EX));

    // R3
    ex_then_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i == ST_EX) |=> (step_i == ST_MEM));

    // R3
    wb_then_if_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i == ST_WB) |=> (step_i == ST_IF));

    // R2
    npc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i == ST_IF) |=> (npc_i == $past(pc_i) + XLEN'(4)));

    // R8
    store_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_i |-> ((step_i == ST_MEM) && (ir_i[31:26] == OP_SW)));

    // R8
    store_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_i |=> (step_i == ST_IF));

    // R10
    zero_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((step_i == ST_ID) && (ir_i[25:21] == 5'd0)) |=> (a_i == '0));

    // R9
    seq_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((step_i == ST_MEM) && (ir_i[31:26] != OP_BEQZ) && (ir_i[31:26] != OP_BNEZ))
        |=> (pc_i == $past(npc_i)));

endmodule

bind mc_core mc_core_chk #(.XLEN(XLEN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_i   (step),
    .pc_i     (dp_q.pc),
    .npc_i    (dp_q.npc),
    .a_i      (dp_q.a),
    .ir_i     (dp_q.ir),
    .mem_we_i (mem_we)
);

// File: tb/mc_core_tb.sv
module mc_core_tb;

    localparam int MWORDS  = 512;
    localparam int RETIRE  = 48;
    localparam int WD_LIM  = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_we;

    always #2 clk = ~clk;

    logic [31:0] mem [MWORDS];
    assign mem_rdata = mem[mem_addr[10:2]];
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr[10:2]] <= mem_wdata;
    end

    mc_core u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_rdata (mem_rdata)
    );

    // behavioural reference: instruction-level model producing a bus trace
    typedef struct {
        logic [31:0] addr;
        logic        we;
        logic [31:0] wdata;
        string       tag;
    } bus_t;

    logic [31:0] ref_mem [MWORDS];
    logic [31:0] ref_reg [32];
    logic [31:0] ref_pc;
    bus_t        exp_q [$];
    int          checks = 0;
    int          fails  = 0;
    bit          done   = 1'b0;

    function automatic logic [31:0] enc_r(int rd, int rs, int rt, int fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 11'(fn)};
    endfunction

    function automatic logic [31:0] enc_i(int op, int rt, int rs, int imm);
        return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
    endfunction

    task automatic put(int idx, logic [31:0] w);
        mem[idx]     = w;
        ref_mem[idx] = w;
    endtask

    task automatic push(logic [31:0] a, logic we, logic [31:0] wd, string tag);
        bus_t e;
        e.addr = a; e.we = we; e.wdata = wd; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp, string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%08h expected=%08h", tag, what, act, exp);
        end
    endtask

    task automatic ref_step();
        logic [31:0] ir  = ref_mem[ref_pc[10:2]];
        logic [5:0]  op  = ir[31:26];
        logic [4:0]  rs  = ir[25:21];
        logic [4:0]  rt  = ir[20:16];
        logic [4:0]  rd  = ir[15:11];
        logic [10:0] fn  = ir[10:0];
        logic [31:0] imm = {{16{ir[15]}}, ir[15:0]};
        logic [31:0] a   = ref_reg[rs];
        logic [31:0] b   = ref_reg[rt];
        logic [31:0] nxt = ref_pc + 32'd4;
        logic [31:0] res = '0;
        logic [4:0]  dst = '0;
        bit          wb  = 1'b0;
        string       tg  = "R11";
        push(ref_pc, 1'b0, '0, "R2");
        push(ref_pc, 1'b0, '0, "R4");
        push(ref_pc, 1'b0, '0, "R3");
        case (op)
            6'h00: begin
                tg = "R5"; wb = 1'b1; dst = rd;
                case (fn)
                    11'h020: res = a + b;
                    11'h022: res = a - b;
                    11'h024: res = a & b;
                    11'h025: res = a | b;
                    11'h026: res = a ^ b;
                    11'h02A: res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
                    default: res = '0;
                endcase
                push(ref_pc, 1'b0, '0, tg);
            end
            6'h08, 6'h0A, 6'h0C, 6'h0D, 6'h0E: begin
                tg = "R6"; wb = 1'b1; dst = rt;
                case (op)
                    6'h08:   res = a + imm;
                    6'h0A:   res = ($signed(a) < $signed(imm)) ? 32'd1 : 32'd0;
                    6'h0C:   res = a & imm;
                    6'h0D:   res = a | imm;
                    default: res = a ^ imm;
                endcase
                push(ref_pc, 1'b0, '0, tg);
            end
            6'h23: begin
                tg = "R7"; wb = 1'b1; dst = rt;
                push(a + imm, 1'b0, '0, tg);
                res = ref_mem[(a + imm) >> 2];
            end
            6'h2B: begin
                push(a + imm, 1'b1, b, "R8");
                ref_mem[(a + imm) >> 2] = b;
            end
            6'h04, 6'h05: begin
                push(ref_pc, 1'b0, '0, "R9");
                if ((op == 6'h04) ? (a == 0) : (a != 0)) nxt = ref_pc + 32'd4 + imm;
            end
            default: push(ref_pc, 1'b0, '0, "R11");
        endcase
        if (wb) begin
            push(nxt, 1'b0, '0, tg);
            if (dst != 0) ref_reg[dst] = res;
        end
        ref_pc = nxt;
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (WD_LIM) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R3 watchdog actual=hung expected=finished");
            summary();
        end
    end

    initial begin
        bus_t e;
        for (int i = 0; i < MWORDS; i++) begin
            mem[i] = '0;
            ref_mem[i] = '0;
        end
        for (int i = 0; i < 32; i++) ref_reg[i] = '0;
        ref_pc = '0;
        put(0,  enc_i(8, 1, 0, 5));
        put(1,  enc_i(8, 2, 0, -3));
        put(2,  enc_r(3, 1, 2, 'h20));
        put(3,  enc_r(4, 1, 2, 'h22));
        put(4,  enc_r(5, 1, 2, 'h24));
        put(5,  enc_r(6, 1, 2, 'h25));
        put(6,  enc_r(7, 1, 2, 'h26));
        put(7,  enc_r(8, 2, 1, 'h2A));
        put(8,  enc_i('h2B, 3, 0, 'h400));
        put(9,  enc_i('h2B, 4, 0, 'h404));
        put(10, enc_i('h2B, 7, 0, 'h408));
        put(11, enc_i('h2B, 8, 0, 'h40C));
        put(12, enc_i(8, 0, 0, 7));
        put(13, enc_i('h2B, 0, 0, 'h410));
        put(14, enc_i('h23, 9, 0, 'h404));
        put(15, enc_i(8, 10, 9, 1));
        put(16, enc_i('h2B, 10, 0, 'h414));
        put(17, enc_i('h04, 0, 0, 8));
        put(18, enc_i(8, 11, 0, 1));
        put(19, enc_i(8, 11, 0, 2));
        put(20, enc_i('h05, 0, 0, 4));
        put(21, enc_i('h2B, 11, 0, 'h418));
        put(22, {6'h3F, 5'd1, 5'd1, 16'h0000});
        put(23, enc_i('h2B, 1, 0, 'h41C));
        put(24, enc_i(8, 12, 0, 77));
        put(25, enc_r(12, 1, 2, 'h3F));
        put(26, enc_i('h2B, 12, 0, 'h420));
        put(27, enc_i('h0A, 13, 2, 0));
        put(28, enc_i('h0D, 14, 1, -16));
        put(29, enc_i('h2B, 13, 0, 'h424));
        put(30, enc_i('h2B, 14, 0, 'h428));
        put(31, enc_i(8, 16, 0, 3));
        put(32, enc_i(8, 15, 15, 2));
        put(33, enc_i(8, 16, 16, -1));
        put(34, enc_i('h05, 0, 16, -12));
        put(35, enc_i('h2B, 15, 0, 'h42C));
        put(36, enc_i('h04, 0, 0, -4));

        // R1: reset state on the port
        repeat (3) begin
            @(negedge clk);
            check("R1", {31'd0, mem_we}, 32'd0, "mem_we in reset");
            check("R1", mem_addr, 32'd0, "mem_addr in reset");
        end
        @(negedge clk);
        rst_n = 1'b1;
        for (int n = 0; n < RETIRE; ) begin
            if (exp_q.size() == 0) begin
                ref_step();
                n++;
            end
            e = exp_q.pop_front();
            #1;
            check(e.tag, mem_addr, e.addr, "mem_addr");
            check(e.tag, {31'd0, mem_we}, {31'd0, e.we}, "mem_we");
            check(e.tag, mem_wdata, e.wdata, "mem_wdata");
            @(negedge clk);
        end
        while (exp_q.size() != 0) begin
            e = exp_q.pop_front();
            #1;
            check(e.tag, mem_addr, e.addr, "mem_addr");
            @(negedge clk);
        end

        // hand-computed results stored by the program
        check("R5",  mem[256], 32'h0000_0002, "add result");
        check("R5",  mem[257], 32'h0000_0008, "sub result");
        check("R5",  mem[258], 32'hFFFF_FFF8, "xor result");
        check("R5",  mem[259], 32'h0000_0001, "slt result");
        check("R10", mem[260], 32'h0000_0000, "r0 after write");
        check("R7",  mem[261], 32'h0000_0009, "loaded value plus one");
        check("R9",  mem[262], 32'h0000_0000, "skipped by taken branch");
        check("R11", mem[263], 32'h0000_0005, "r1 after unknown opcode");
        check("R5",  mem[264], 32'h0000_0000, "unknown function");
        check("R6",  mem[265], 32'h0000_0001, "slti result");
        check("R6",  mem[266], 32'hFFFF_FFF5, "ori sign-extended");
        check("R9",  mem[267], 32'h0000_0006, "loop count");
        for (int i = 0; i < MWORDS; i++) begin
            check("R8", mem[i], ref_mem[i], "memory image");
        end
        done = 1'b1;
        summary();
    end

endmodule